// File: doc/BRIEF.md
# Angle Change Alert Monitor

This block watches a set of angle channels and tells the host when any of them has turned further than a chosen amount. Each channel carries an unsigned angle word whose top bit weighs half a turn. The host gives each channel its own threshold in that same weighting. A threshold of zero switches the channel off, and every channel starts in that state.

An initiate strobe arms monitoring. It also takes a snapshot of every channel's present angle as that channel's reference. From then on, the block compares each live angle with its reference by wrap-around subtraction. A move across the zero point is therefore measured as the short way round. When the size of that move rises above the channel's threshold, the channel's flag is set and stays set.

The OR of all flags forms an interrupt request, which can be enabled or masked. The request is presented together with an 8-bit vector that is reserved for angle alerts. A host read of the flag register clears the flags after the read. A new initiate clears them as well and takes a fresh snapshot of the references. The host therefore waits for the interrupt and never has to poll the angle words.

Top module: `angle_alert_mon`

## Requirements
- R1: After synchronous reset, `flags_o` is all zero, `irq_o` is 0, `irq_vec_o` is 0, and every channel threshold is zero, which means every channel is disabled.
- R2: Before the first initiate after reset, no flag is set, whatever the angles and thresholds are.
- R3: A channel whose threshold is zero never sets its flag, however far its angle moves.
- R4: For an armed channel with a nonzero threshold T, flag bit n is set on the first clock edge at which |current − reference| > T, and it is visible on `flags_o` after that edge. A difference exactly equal to T does not set the flag.
- R5: The difference is the signed ANG_W-bit wrap-around result of (current − reference), taken as its magnitude. A move from 0xFFF0 to 0x0008 counts as 0x18, and a move from 0x0005 to 0xFFF4 counts as 0x11.
- R6: A set flag stays set after the angle returns within threshold. It stays set until a flag read or an initiate.
- R7: A one-cycle `flag_rd_i` pulse clears all flags at that clock edge. A channel that exceeds its threshold in that same cycle is flagged anyway.
- R8: An `arm_i` pulse captures every channel's current angle as its new reference and clears all flags at that edge. Comparisons against the new references start on the next cycle.
- R9: `irq_o` equals `irq_en_i` AND the OR of the flags, registered at the same edge as the flags. It drops when the flags are cleared or when `irq_en_i` goes low.
- R10: A `vec_we_i` write loads `vec_din_i` into the alert vector. The vector appears on `irq_vec_o` after that edge.
- R11: A displacement of exactly half a turn (difference 0x8000 for ANG_W=16) exceeds every programmable threshold, including 0x7FFF.
- R12: A threshold write whose `cfg_ch_i` is NUM_CH or larger changes no channel. A write to a valid channel changes only that channel's threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| angles_i | input | NUM_CH*ANG_W | Live angle words; channel n sits in bits [n*ANG_W +: ANG_W] |
| cfg_we_i | input | 1 | Threshold write strobe |
| cfg_ch_i | input | CH_IDX_W | Channel index for the threshold write |
| cfg_thr_i | input | ANG_W | Threshold value; 0 disables the channel |
| arm_i | input | 1 | Initiate: snapshot references, clear flags, enable monitoring |
| flag_rd_i | input | 1 | Host read of the flag register; clears the flags after the read |
| irq_en_i | input | 1 | Interrupt enable |
| vec_we_i | input | 1 | Alert vector write strobe |
| vec_din_i | input | VEC_W | Alert vector write data |
| flags_o | output | NUM_CH | Sticky per-channel change flags (1 = changed) |
| irq_o | output | 1 | Alert interrupt request |
| irq_vec_o | output | VEC_W | Alert interrupt vector |

## Verification
The bench builds the block with NUM_CH=5, ANG_W=16 and VEC_W=8. With five channels the index is three bits wide, so indices 5 to 7 exist on the port but name no channel. The bench writes to one of these indices to check that such a write alters no threshold. ANG_W=16 keeps the true half-turn weighting, so the bench can drive the wrap cases around 0xFFFF/0x0000 and the exact 0x8000 displacement against a threshold of 0x7FFF. Five channels are enough to hold one disabled channel, one wrapping forward and one wrapping backward side by side.

// File: rtl/angle_alert_pkg.sv
package angle_alert_pkg;

  // Update applied to the sticky flag register on a clock edge
  typedef enum logic [1:0] {
    FLG_ACCUM  = 2'd0,  // keep old flags, OR in new hits
    FLG_REARM  = 2'd1,  // clear everything, ignore hits
    FLG_RDCLR  = 2'd2   // drop old flags, keep only new hits
  } flag_op_e;

endpackage

// File: rtl/alert_thr_bank.sv
module alert_thr_bank #(
  parameter int NUM_CH   = 16,
  parameter int ANG_W    = 16,
  parameter int CH_IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we_i,
  input  logic [CH_IDX_W-1:0]     ch_i,
  input  logic [ANG_W-1:0]        thr_i,
  output logic [NUM_CH*ANG_W-1:0] thr_o
);

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_thr
    logic [ANG_W-1:0] thr_q;
    logic             sel;

    assign sel = we_i && (ch_i == CH_IDX_W'(gi));

    always_ff @(posedge clk) begin
      if (rst)      thr_q <= '0;
      else if (sel) thr_q <= thr_i;
    end

    assign thr_o[gi*ANG_W +: ANG_W] = thr_q;
  end

endmodule

// File: rtl/alert_chan.sv
module alert_chan #(
  parameter int ANG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_i,
  input  logic             armed_i,
  input  logic [ANG_W-1:0] angle_i,
  input  logic [ANG_W-1:0] thr_i,
  output logic             hit_o
);

  logic [ANG_W-1:0] ref_q;
  logic [ANG_W-1:0] delta;
  logic [ANG_W-1:0] mag;

  always_ff @(posedge clk) begin
    if (rst)            ref_q <= '0;
    else if (capture_i) ref_q <= angle_i;
  end

  // modular difference, then magnitude of its signed reading
  assign delta = angle_i - ref_q;
  assign mag   = delta[ANG_W-1] ? (~delta + ANG_W'(1)) : delta;

  assign hit_o = armed_i && (thr_i != '0) && (mag > thr_i);

endmodule

// File: rtl/alert_flag_reg.sv
module alert_flag_reg
  import angle_alert_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  flag_op_e          op_i,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic              irq_en_i,
  output logic [NUM_CH-1:0] flags_o,
  output logic              irq_o
);

  logic [NUM_CH-1:0] flags_q;
  logic [NUM_CH-1:0] flags_nxt;
  logic              irq_q;

  always_comb begin
    case (op_i)
      FLG_REARM: flags_nxt = '0;
      FLG_RDCLR: flags_nxt = hit_i;
      default:   flags_nxt = flags_q | hit_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_nxt;
      irq_q   <= irq_en_i && (|flags_nxt);
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/angle_alert_mon.sv
module angle_alert_mon
  import angle_alert_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int ANG_W    = 16,
  parameter int VEC_W    = 8,
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*ANG_W-1:0] angles_i,
  input  logic                    cfg_we_i,
  input  logic [CH_IDX_W-1:0]     cfg_ch_i,
  input  logic [ANG_W-1:0]        cfg_thr_i,
  input  logic                    arm_i,
  input  logic                    flag_rd_i,
  input  logic                    irq_en_i,
  input  logic                    vec_we_i,
  input  logic [VEC_W-1:0]        vec_din_i,
  output logic [NUM_CH-1:0]       flags_o,
  output logic                    irq_o,
  output logic [VEC_W-1:0]        irq_vec_o
);

  logic [NUM_CH*ANG_W-1:0] thr_all;
  logic [NUM_CH-1:0]       hit;
  logic                    armed_q;
  logic [VEC_W-1:0]        vec_q;
  flag_op_e                op;

  always_ff @(posedge clk) begin
    if (rst)        armed_q <= 1'b0;
    else if (arm_i) armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           vec_q <= '0;
    else if (vec_we_i) vec_q <= vec_din_i;
  end
  assign irq_vec_o = vec_q;

  // initiate outranks a read in the same cycle
  always_comb begin
    if (arm_i)          op = FLG_REARM;
    else if (flag_rd_i) op = FLG_RDCLR;
    else                op = FLG_ACCUM;
  end

  alert_thr_bank #(
    .NUM_CH   (NUM_CH),
    .ANG_W    (ANG_W),
    .CH_IDX_W (CH_IDX_W)
  ) u_thr_bank (
    .clk   (clk),
    .rst   (rst),
    .we_i  (cfg_we_i),
    .ch_i  (cfg_ch_i),
    .thr_i (cfg_thr_i),
    .thr_o (thr_all)
  );

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chan
    alert_chan #(.ANG_W(ANG_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .capture_i (arm_i),
      .armed_i   (armed_q),
      .angle_i   (angles_i[gc*ANG_W +: ANG_W]),
      .thr_i     (thr_all[gc*ANG_W +: ANG_W]),
      .hit_o     (hit[gc])
    );
  end

  alert_flag_reg #(.NUM_CH(NUM_CH)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op),
    .hit_i    (hit),
    .irq_en_i (irq_en_i),
    .flags_o  (flags_o),
    .irq_o    (irq_o)
  );

endmodule

// File: rtl/angle_alert_mon_chk.sv
module angle_alert_mon_chk #(
  parameter int NUM_CH = 16,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              arm_i,
  input logic              flag_rd_i,
  input logic              vec_we_i,
  input logic [VEC_W-1:0]  vec_din_i,
  input logic [NUM_CH-1:0] flags_o,
  input logic              irq_o,
  input logic [VEC_W-1:0]  irq_vec_o
);

  logic seen_arm_q;
  logic was_rst_q;

  always_ff @(posedge clk) begin
    was_rst_q <= rst;
    if (rst)        seen_arm_q <= 1'b0;
    else if (arm_i) seen_arm_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    // R1
    if (was_rst_q) reset_state_chk: assert (flags_o == '0 && !irq_o && irq_vec_o == '0);
    // R2
    if (!rst && !seen_arm_q) unarmed_quiet_chk: assert (flags_o == '0);
  end

  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_rd_i && !arm_i) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R8
  arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (flags_o == '0));

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flags_o != '0));

  // R10
  vec_load_chk: assert property (@(posedge clk) disable iff (rst)
    vec_we_i |=> (irq_vec_o == $past(vec_din_i)));

endmodule

bind angle_alert_mon angle_alert_mon_chk #(
  .NUM_CH (NUM_CH),
  .VEC_W  (VEC_W)
) u_angle_alert_mon_chk (
  .clk       (clk),
  .rst       (rst),
  .arm_i     (arm_i),
  .flag_rd_i (flag_rd_i),
  .vec_we_i  (vec_we_i),
  .vec_din_i (vec_din_i),
  .flags_o   (flags_o),
  .irq_o     (irq_o),
  .irq_vec_o (irq_vec_o)
);

// File: tb/angle_alert_mon_bench.sv
`timescale 1ns/1ps
module angle_alert_mon_bench;

  localparam int NCH = 5;
  localparam int AW  = 16;
  localparam int VW  = 8;
  localparam int IW  = 3;

  logic            clk = 1'b0;
  logic            rst;
  logic [NCH*AW-1:0] angles;
  logic            cfg_we;
  logic [IW-1:0]   cfg_ch;
  logic [AW-1:0]   cfg_thr;
  logic            arm;
  logic            flag_rd;
  logic            irq_en;
  logic            vec_we;
  logic [VW-1:0]   vec_din;
  logic [NCH-1:0]  flags;
  logic            irq;
  logic [VW-1:0]   irq_vec;

  logic [AW-1:0]   ang [NCH];

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) angles[i*AW +: AW] = ang[i];
  end

  angle_alert_mon #(.NUM_CH(NCH), .ANG_W(AW), .VEC_W(VW)) u_angle_alert_mon (
    .clk       (clk),
    .rst       (rst),
    .angles_i  (angles),
    .cfg_we_i  (cfg_we),
    .cfg_ch_i  (cfg_ch),
    .cfg_thr_i (cfg_thr),
    .arm_i     (arm),
    .flag_rd_i (flag_rd),
    .irq_en_i  (irq_en),
    .vec_we_i  (vec_we),
    .vec_din_i (vec_din),
    .flags_o   (flags),
    .irq_o     (irq),
    .irq_vec_o (irq_vec)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_thr(input int ch, input logic [AW-1:0] v);
    cfg_we = 1'b1; cfg_ch = IW'(ch); cfg_thr = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    step();
    arm = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flags", 32'(flags), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 vector", 32'(irq_vec), 0);
  endtask

  task automatic t_prearm();
    for (int i = 0; i < NCH; i++) ang[i] = 16'd1000;
    step();
    wr_thr(0, 16'd100);
    ang[0] = 16'd5000;
    step();
    chk("R2 no flag before initiate", 32'(flags), 0);
    ang[0] = 16'd1000;
  endtask

  task automatic t_threshold();
    wr_thr(2, 16'd50);
    wr_thr(3, 16'h0020);
    wr_thr(4, 16'h0010);
    do_arm();
    chk("R8 flags clear after initiate", 32'(flags), 0);
    ang[0] = 16'd1100;
    step();
    chk("R4 equal to threshold", 32'(flags), 0);
    ang[0] = 16'd1101;
    step();
    chk("R4 above threshold", 32'(flags), 32'h01);
    chk("R9 irq raised", 32'(irq), 1);
    ang[1] = 16'd21000;
    step();
    chk("R3 zero threshold disabled", 32'(flags), 32'h01);
    ang[1] = 16'd1000;
  endtask

  task automatic t_sticky();
    ang[0] = 16'd1000;
    step();
    chk("R6 flag sticky", 32'(flags), 32'h01);
    chk("R6 irq held", 32'(irq), 1);
  endtask

  task automatic t_read();
    flag_rd = 1'b1;
    step();
    flag_rd = 1'b0;
    chk("R7 read clears", 32'(flags), 0);
    chk("R9 irq drops", 32'(irq), 0);
    ang[2] = 16'd949;
    flag_rd = 1'b1;
    step();
    flag_rd = 1'b0;
    chk("R7 hit during read kept", 32'(flags), 32'h04);
    ang[2] = 16'd1000;
    irq_en = 1'b0;
    step();
    chk("R9 irq masked", 32'(irq), 0);
    chk("R9 flags kept when masked", 32'(flags), 32'h04);
    irq_en = 1'b1;
    step();
    chk("R9 irq re-enabled", 32'(irq), 1);
  endtask

  task automatic t_wrap();
    ang[3] = 16'hFFF0;
    ang[4] = 16'h0005;
    do_arm();
    chk("R8 initiate clears old flag", 32'(flags), 0);
    chk("R8 irq cleared", 32'(irq), 0);
    ang[3] = 16'h0008;
    step();
    chk("R5 forward wrap within", 32'(flags), 0);
    ang[3] = 16'h0011;
    step();
    chk("R5 forward wrap beyond", 32'(flags), 32'h08);
    ang[4] = 16'hFFF4;
    step();
    chk("R5 backward wrap beyond", 32'(flags), 32'h18);
  endtask

  task automatic t_half();
    wr_thr(0, 16'h7FFF);
    ang[0] = 16'h0000;
    do_arm();
    chk("R8 rearm", 32'(flags), 0);
    ang[0] = 16'h8000;
    step();
    chk("R11 half turn flagged", 32'(flags), 32'h01);
  endtask

  task automatic t_badch();
    do_arm();
    wr_thr(7, 16'h0001);
    ang[0] = 16'hFFFF;
    ang[1] = 16'd1001;
    ang[2] = 16'd1050;
    ang[3] = 16'h0031;
    ang[4] = 16'h0004;
    step();
    chk("R12 out-of-range write ignored", 32'(flags), 0);
    wr_thr(1, 16'h0001);
    chk("R12 equal after own write", 32'(flags), 0);
    ang[1] = 16'd1002;
    step();
    chk("R12 own channel only", 32'(flags), 32'h02);
  endtask

  task automatic t_vec();
    vec_we = 1'b1; vec_din = 8'hA5;
    step();
    vec_we = 1'b0;
    chk("R10 vector A5", 32'(irq_vec), 32'hA5);
    vec_we = 1'b1; vec_din = 8'h3C;
    step();
    vec_we = 1'b0;
    chk("R10 vector 3C", 32'(irq_vec), 32'h3C);
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_ch = '0; cfg_thr = '0;
    arm = 1'b0; flag_rd = 1'b0; irq_en = 1'b1; vec_we = 1'b0; vec_din = '0;
    for (int i = 0; i < NCH; i++) ang[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_prearm();
    t_threshold();
    t_sticky();
    t_read();
    t_wrap();
    t_half();
    t_badch();
    t_vec();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog (all R): actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule